// File: doc/BRIEF.md
# Double-Buffered Serial Control Word Receiver

This block is the device-side receiver for a serial control word. It is the logic that sits behind the control pins of a step attenuator, a switch or a gain stage. A host shifts the word in over a serial clock and a data line while the device's select line is held low. The bits pass into a shift register that has no path to the pins. A separate holding register drives the parallel control output. That register takes the whole shifted word in a single clock only when the load strobe rises. A change of code therefore never passes through a mix of old and new bits.

All four serial pins are sampled by the block's own clock through a synchronizer of configurable depth. Edges of the serial clock and of the load strobe are found in that clock domain. The word length is a parameter and may only be 24 or 32. The output reset value is also a parameter. A load strobe that arrives before a complete word is refused: the output keeps its code and a sticky short-word flag rises. The next accepted load clears the flag.

Top module: `lscr_top`

## Requirements
- R1: While reset is active, and after it, the control output equals the SAFE_CODE parameter and the short-word flag is 0.
- R2: A rising load strobe with a complete word pending copies all WORD_BITS bits to the control output at once. The first bit shifted in lands at the most significant output bit and the last bit at bit 0.
- R3: The control output changes only in the clock after an accepted load strobe. While bits are being shifted it keeps its previous code, and a change from 15 to 16 shows no other value on the way.
- R4: Bits are taken only on rising serial-clock edges while select is low. The bit count clears whenever select is high, so serial clocks with select high are ignored and a word split across two select frames is not complete.
- R5: When more than WORD_BITS bits arrive in one frame, the oldest bits fall out and the last WORD_BITS bits are the word kept.
- R6: A rising load strobe without a complete word leaves the control output unchanged and sets the short-word flag.
- R7: An accepted load clears the short-word flag. A second load after the same complete frame re-applies the same word without error.
- R8: A complete word may also be loaded while select is still low, before the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| csn | input | 1 | Active-low device select |
| le | input | 1 | Load strobe; rising edge moves the word to the output |
| ctrl_out | output | WORD_BITS | Parallel control code |
| err_short | output | 1 | Sticky flag: last load strobe found no complete word |

## Verification
The assertions assume that each serial pin stays at one level for longer than the synchronizer depth plus one block clock. Under that assumption, every edge of the serial clock and of the load strobe is seen exactly once, and the data bit is settled when its clock edge is detected. The stimulus holds every serial phase for four block clocks and changes data only while the serial clock is low. It always keeps the load strobe high and low for several clocks, so no edge is lost or doubled. It also pulses the strobe only when select is stable, except in the check that loads a word while select is still low.

// File: rtl/lscr_pkg.sv
package lscr_pkg;

   // Word lengths the receiver is built for.
   localparam int unsigned LEN_SHORT = 24;
   localparam int unsigned LEN_LONG  = 32;
   localparam int unsigned MAX_SYNC  = 4;

   // Width of a counter that must hold the value 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   function automatic bit len_ok(input int unsigned n);
      return (n == LEN_SHORT) || (n == LEN_LONG);
   endfunction

endpackage

// File: rtl/lscr_sync.sv
module lscr_sync #(
   parameter int unsigned           N_BITS  = 4,
   parameter int unsigned           STAGES  = 2,
   parameter logic [N_BITS-1:0]     RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] d,
   output logic [N_BITS-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         // Inputs already in the block clock domain.
         assign q = d;
      end else begin : g_chain
         logic [N_BITS-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lscr_shifter.sv
module lscr_shifter #(
   parameter int unsigned W     = 24,
   localparam int unsigned CNT_W = lscr_pkg::cnt_width(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             sdi_s,
   input  logic             csn_s,
   output logic [W-1:0]     shreg,
   output logic [CNT_W-1:0] cnt,
   output logic             word_ok
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

   logic sclk_q;
   logic csn_q;
   logic armed;
   logic sclk_rise;
   logic take_bit;
   logic frame_start;
   logic frame_end;

   assign sclk_rise   = sclk_s & ~sclk_q;
   assign take_bit    = sclk_rise & ~csn_s;
   assign frame_start = csn_q & ~csn_s;
   assign frame_end   = csn_s & ~csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         csn_q  <= csn_s;
      end
   end

   // Shift path: newest bit enters at bit 0, so the first bit ends on top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (take_bit) begin
         shreg <= {shreg[W-2:0], sdi_s};
      end
   end

   // Saturating bit count, cleared whenever select is inactive.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (csn_s) begin
         cnt <= '0;
      end else if (take_bit && (cnt != FULL)) begin
         cnt <= cnt + 1'b1;
      end
   end

   // Remembers, after a frame closes, whether it delivered a full word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (frame_start) begin
         armed <= 1'b0;
      end else if (frame_end) begin
         armed <= (cnt == FULL);
      end
   end

   // Inside a frame the live count decides; outside it the remembered flag.
   assign word_ok = csn_q ? armed : (cnt == FULL);

endmodule

// File: rtl/lscr_latch.sv
module lscr_latch #(
   parameter int unsigned   W         = 24,
   parameter logic [W-1:0]  SAFE_WORD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le_s,
   input  logic         word_ok,
   input  logic [W-1:0] shreg,
   output logic [W-1:0] hold,
   output logic         err,
   output logic         le_rise,
   output logic         accept
);

   logic le_q;

   assign le_rise = le_s & ~le_q;
   assign accept  = word_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_q <= 1'b0;
      end else begin
         le_q <= le_s;
      end
   end

   // Holding register: every bit moves in the same clock.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= SAFE_WORD;
      end else if (le_rise && word_ok) begin
         hold <= shreg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else if (le_rise) begin
         err <= ~word_ok;
      end
   end

endmodule

// File: rtl/lscr_top.sv
module lscr_top #(
   parameter int unsigned WORD_BITS   = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] SAFE_CODE   = 32'h0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk,
   input  logic                 sdi,
   input  logic                 csn,
   input  logic                 le,
   output logic [WORD_BITS-1:0] ctrl_out,
   output logic                 err_short
);

   localparam int unsigned CNT_W = lscr_pkg::cnt_width(WORD_BITS);
   // Pin order in the synchronized vector: {csn, le, sclk, sdi}.
   localparam logic [3:0]  PIN_IDLE = 4'b1000;

   generate
      if (!lscr_pkg::len_ok(WORD_BITS)) begin : g_bad_len
         $error("lscr_top: WORD_BITS must be 24 or 32");
      end
      if (SYNC_STAGES > lscr_pkg::MAX_SYNC) begin : g_bad_sync
         $error("lscr_top: SYNC_STAGES too large");
      end
   endgenerate

   logic [3:0]           pins_s;
   logic                 csn_s;
   logic                 le_s;
   logic                 sclk_s;
   logic                 sdi_s;
   logic [WORD_BITS-1:0] shreg;
   logic [CNT_W-1:0]     cnt;
   logic                 word_ok;
   logic                 le_rise;
   logic                 accept;

   lscr_sync #(
      .N_BITS  (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({csn, le, sclk, sdi}),
      .q     (pins_s)
   );

   assign {csn_s, le_s, sclk_s, sdi_s} = pins_s;

   lscr_shifter #(
      .W (WORD_BITS)
   ) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .sdi_s   (sdi_s),
      .csn_s   (csn_s),
      .shreg   (shreg),
      .cnt     (cnt),
      .word_ok (word_ok)
   );

   lscr_latch #(
      .W         (WORD_BITS),
      .SAFE_WORD (SAFE_CODE[WORD_BITS-1:0])
   ) latch_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .le_s    (le_s),
      .word_ok (word_ok),
      .shreg   (shreg),
      .hold    (ctrl_out),
      .err     (err_short),
      .le_rise (le_rise),
      .accept  (accept)
   );

endmodule

// File: rtl/lscr_chk.sv
module lscr_chk #(
   parameter int unsigned W     = 24,
   localparam int unsigned CNT_W = lscr_pkg::cnt_width(W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [W-1:0]     ctrl_out,
   input logic             err_short,
   input logic             le_rise,
   input logic             accept,
   input logic [W-1:0]     shreg,
   input logic [CNT_W-1:0] cnt,
   input logic             csn_s
);

   p_load_whole_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && accept) |=> (ctrl_out == $past(shreg)));

   p_no_stray_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_out) |-> $past(le_rise && accept));

   p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> (cnt == '0));

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(W));

   p_short_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && !accept) |=> ($stable(ctrl_out) && err_short));

   p_flag_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && accept) |=> !err_short);

endmodule

bind lscr_top lscr_chk #(.W(WORD_BITS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_out  (ctrl_out),
   .err_short (err_short),
   .le_rise   (le_rise),
   .accept    (accept),
   .shreg     (shreg),
   .cnt       (cnt),
   .csn_s     (csn_s)
);

// File: tb/lscr_top_tb_top.sv
module lscr_top_tb_top;

   localparam int unsigned W    = 24;
   localparam logic [31:0] SAFE = 32'h00C3A5;
   localparam int unsigned NVEC = 7;

   // Vector: {bit count, data shifted from its bit count-1 down to 0, expected out, expected flag}
   localparam logic [5:0]   V_N   [NVEC] = '{6'd24, 6'd24, 6'd24, 6'd10, 6'd24, 6'd30, 6'd0};
   localparam logic [39:0]  V_D   [NVEC] = '{40'h00000F, 40'h000010, 40'hFFFFFF, 40'h3FF,
                                            40'h123456, 40'h3ABCDEF1, 40'h0};
   localparam logic [23:0]  V_OUT [NVEC] = '{24'h00000F, 24'h000010, 24'hFFFFFF, 24'hFFFFFF,
                                            24'h123456, 24'hBCDEF1, 24'hBCDEF1};
   localparam logic         V_ERR [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk = 1'b0;
   logic         sdi = 1'b0;
   logic         csn = 1'b1;
   logic         le = 1'b0;
   logic [W-1:0] ctrl_out;
   logic         err_short;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [W-1:0] mon_old = '0;
   logic [W-1:0] mon_new = '0;
   bit           mon_on = 1'b0;
   int           glitches = 0;

   always #4 clk = ~clk;

   lscr_top #(
      .WORD_BITS   (W),
      .SYNC_STAGES (2),
      .SAFE_CODE   (SAFE)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .csn       (csn),
      .le        (le),
      .ctrl_out  (ctrl_out),
      .err_short (err_short)
   );

   // Output may only ever show the old or the new code while a vector runs.
   always @(negedge clk) begin
      if (mon_on && (ctrl_out !== mon_old) && (ctrl_out !== mon_new)) glitches++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [39:0] data, input int nb);
      for (int i = nb - 1; i >= 0; i--) begin
         sdi = data[i];
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
   endtask

   task automatic send_frame(input logic [39:0] data, input int nb);
      csn = 1'b0;
      wait_clk(4);
      shift_bits(data, nb);
      csn = 1'b1;
      wait_clk(6);
   endtask

   task automatic pulse_le();
      le = 1'b1;
      wait_clk(5);
      le = 1'b0;
      wait_clk(8);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] prev;
      // R1: reset value during and after reset
      wait_clk(3);
      check("R1 out in reset", 32'(ctrl_out), SAFE);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1 out after reset", 32'(ctrl_out), SAFE);
      check("R1 flag after reset", 32'(err_short), 32'd0);

      prev = SAFE[W-1:0];
      for (int v = 0; v < int'(NVEC); v++) begin
         mon_old = prev;
         mon_new = V_OUT[v];
         glitches = 0;
         mon_on = 1'b1;
         send_frame(V_D[v], int'(V_N[v]));
         // R3: nothing reaches the pins before the strobe
         check("R3 held before strobe", 32'(ctrl_out), 32'(prev));
         pulse_le();
         mon_on = 1'b0;
         // R2 full loads, R5 overlong frame, R6 short frames
         check(V_ERR[v] ? "R6 out kept" : (V_N[v] > 24 ? "R5 last word kept" : "R2 word loaded"),
               32'(ctrl_out), 32'(V_OUT[v]));
         check(V_ERR[v] ? "R6 flag set" : "R7 flag clear", 32'(err_short), 32'(V_ERR[v]));
         // R3: 15 -> 16 and every other change without intermediate codes
         check("R3 no intermediate code", 32'(glitches), 32'd0);
         prev = V_OUT[v];
      end

      // R4: serial clocks with select high are ignored
      for (int i = 0; i < 30; i++) begin
         sdi = 1'b1;
         wait_clk(4);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
      pulse_le();
      check("R4 clocks without select ignored", 32'(ctrl_out), 32'hBCDEF1);
      check("R4 flag after idle clocks", 32'(err_short), 32'd1);

      // R4: a word split over two frames is not complete
      send_frame(40'hABC, 12);
      send_frame(40'hDEF, 12);
      pulse_le();
      check("R4 split word refused", 32'(ctrl_out), 32'hBCDEF1);
      check("R4 split word flag", 32'(err_short), 32'd1);

      // R8: load while select still low
      csn = 1'b0;
      wait_clk(4);
      shift_bits(40'h0F0F0F, 24);
      pulse_le();
      check("R8 load inside frame", 32'(ctrl_out), 32'h0F0F0F);
      check("R8 flag cleared", 32'(err_short), 32'd0);
      csn = 1'b1;
      wait_clk(6);

      // R7: a second strobe reuses the same word without error
      pulse_le();
      check("R7 repeat strobe out", 32'(ctrl_out), 32'h0F0F0F);
      check("R7 repeat strobe flag", 32'(err_short), 32'd0);

      // R7: flag set by a short frame, then cleared by a full one
      send_frame(40'h5, 3);
      pulse_le();
      check("R6 short after good", 32'(err_short), 32'd1);
      send_frame(40'h800001, 24);
      pulse_le();
      check("R2 msb first", 32'(ctrl_out), 32'h800001);
      check("R7 flag cleared by load", 32'(err_short), 32'd0);

      // R1: reset in the middle of a frame restores the safe code
      csn = 1'b0;
      wait_clk(4);
      shift_bits(40'h777, 12);
      rst_n = 1'b0;
      wait_clk(2);
      check("R1 reset mid frame out", 32'(ctrl_out), SAFE);
      csn = 1'b1;
      rst_n = 1'b1;
      wait_clk(6);
      pulse_le();
      check("R1 no word after reset", 32'(ctrl_out), SAFE);
      check("R6 flag after reset strobe", 32'(err_short), 32'd1);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule